// File: doc/BRIEF.md
# Buffered SPI Master with Transmit and Receive Queues

This block is a single-device SPI master. Software pushes 8-bit words into a 16-entry transmit queue and pulls received words out of a 16-entry receive queue. Both queues, a control register, a sticky interrupt status register and an interrupt enable register sit behind a small register bus. Every bus access is acknowledged one cycle later. An access that a full or empty queue cannot honour is acknowledged together with an error flag.

The serial side runs SPI mode 0. The clock idles low, both sides sample on the rising edge and shift on the falling edge, and words go out most significant bit first. The serial clock is the bus clock divided by an even ratio fixed at elaboration. Words go out in two ways. With the enable bit already set, a burst starts as soon as the first word is queued. Otherwise a queue preloaded with enable clear starts draining when the enable bit is set. The active-low select is held low across consecutive words and released only when the queue has run dry and the last word has finished. A loop bit feeds the serial output back into the receiver, so the part can test itself without a slave.

Top module: `spi_fifo_master`

## Requirements
- R1: Every bus request is acknowledged on the next cycle. A write to the transmit data register (address 1) while the transmit queue holds 16 words is acknowledged with the error flag set, and the word is not stored.
- R2: A read of the receive data register (address 2) while the receive queue is empty is acknowledged with the error flag set and returns 0.
- R3: Reads of address 2 return received words in arrival order, one word per read. After N completed transfers into an empty queue, exactly N reads succeed, and the next read reports an error.
- R4: A transfer that completes while the receive queue holds 16 words is discarded, and status bit 3 (overrun) is set.
- R5: Status bit 2 (receive full) is set when a completed transfer brings the receive queue to 16 words.
- R6: Status bit 0 (transmit empty) is set when the last queued word is taken for sending. Status bit 1 (transmit half empty) is set when the transmit occupancy drops from 9 to 8. Status bit 4 (transmit underrun) always reads 0.
- R7: With control bit 0 (enable) set, a write into an empty transmit queue pulls the select line low within 2 cycles after its acknowledge.
- R8: While enable is clear, no transfer starts. Once enable is set, all queued words are sent in queue order, and the select line stays low for the whole burst, rising exactly once at its end.
- R9: With control bit 1 (loop) set, each received word equals the word sent, and the MISO pin has no effect.
- R10: The serial clock idles low while select is high. Each word takes 8 rising edges, spaced SCK_RATIO bus cycles apart within a burst. MOSI is driven most significant bit first and changes only while the clock is low.
- R11: Status bits (address 3) are sticky and are cleared by writing 1 to them. The irq output is high exactly when some status bit and its bit in the interrupt enable register (address 4) are both 1. Control (address 0) reads back enable in bit 0 and loop in bit 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rstN | input | 1 | Active-low synchronous reset |
| busReq | input | 1 | One-cycle access request |
| busWe | input | 1 | 1 = write, 0 = read |
| busAddr | input | ADDR_W | Register address |
| busWdata | input | DATA_W | Write data |
| busAck | output | 1 | Acknowledge, one cycle after busReq |
| busErr | output | 1 | Error flag returned with busAck |
| busRdata | output | DATA_W | Read data returned with busAck |
| sck | output | 1 | Serial clock, mode 0 |
| ssN | output | 1 | Active-low slave select |
| mosi | output | 1 | Serial data out |
| miso | input | 1 | Serial data in |
| irq | output | 1 | Interrupt request |

## Verification
The hardest state to reach from the ports is a transfer that completes into a completely full receive queue. Reaching it needs sixteen full transfers with no bus reads in between, and then one more word sent through the serial engine. The bench gets there by preloading sixteen words with enable clear, running the burst, and then queuing a seventeenth word. It then drains the receive queue and confirms that only the first sixteen slave responses come back. Loopback is swept over all 256 byte values, while the slave model drives a different pattern on MISO.

// File: rtl/sfm_pkg.sv
package sfm_pkg;
  // strobes from control to datapath
  typedef struct packed {
    logic txPush;
    logic rxPop;
    logic loadShift;
    logic sampleBit;
    logic shiftBit;
    logic rxPush;
  } dpStrobe_t;

  localparam int ST_TXEMPTY  = 0;
  localparam int ST_TXHALF   = 1;
  localparam int ST_RXFULL   = 2;
  localparam int ST_OVERRUN  = 3;
  localparam int ST_UNDERRUN = 4;
  localparam int NUM_IRQ     = 5;

  localparam int ADDR_CTRL = 0;
  localparam int ADDR_TX   = 1;
  localparam int ADDR_RX   = 2;
  localparam int ADDR_STAT = 3;
  localparam int ADDR_IEN  = 4;
endpackage

// File: rtl/sfm_fifo.sv
module sfm_fifo #(
  parameter int W     = 8,
  parameter int DEPTH = 16,
  localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int CNT_W = $clog2(DEPTH + 1)
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             push,
  input  logic [W-1:0]     pushData,
  input  logic             pop,
  output logic [W-1:0]     head,
  output logic [CNT_W-1:0] count
);
  logic [W-1:0]     mem [DEPTH];
  logic [PTR_W-1:0] wrPtr, rdPtr;

  function automatic logic [PTR_W-1:0] nextPtr(input logic [PTR_W-1:0] p);
    return (p == PTR_W'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  always_ff @(posedge clk) begin
    if (push) mem[wrPtr] <= pushData;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      wrPtr <= '0;
      rdPtr <= '0;
      count <= '0;
    end else begin
      if (push) wrPtr <= nextPtr(wrPtr);
      if (pop)  rdPtr <= nextPtr(rdPtr);
      if (push && !pop)      count <= count + 1'b1;
      else if (pop && !push) count <= count - 1'b1;
    end
  end

  assign head = mem[rdPtr];
endmodule

// File: rtl/sfm_datapath.sv
module sfm_datapath import sfm_pkg::*; #(
  parameter int W     = 8,
  parameter int DEPTH = 16,
  localparam int CNT_W = $clog2(DEPTH + 1)
) (
  input  logic             clk,
  input  logic             rstN,
  input  dpStrobe_t        stb,
  input  logic [W-1:0]     wrData,
  input  logic             misoPin,
  input  logic             loopEn,
  output logic             mosi,
  output logic [CNT_W-1:0] txCount,
  output logic [CNT_W-1:0] rxCount,
  output logic [W-1:0]     rxHead
);
  logic [W-1:0] txHead, shiftReg, rxWord;
  logic         inBit, serialIn;

  sfm_fifo #(.W(W), .DEPTH(DEPTH)) txFifo_i (
    .clk(clk), .rstN(rstN), .push(stb.txPush), .pushData(wrData),
    .pop(stb.loadShift), .head(txHead), .count(txCount));

  sfm_fifo #(.W(W), .DEPTH(DEPTH)) rxFifo_i (
    .clk(clk), .rstN(rstN), .push(stb.rxPush), .pushData(rxWord),
    .pop(stb.rxPop), .head(rxHead), .count(rxCount));

  assign mosi     = shiftReg[W-1];
  assign serialIn = loopEn ? mosi : misoPin;
  assign rxWord   = {shiftReg[W-2:0], inBit};

  always_ff @(posedge clk) begin
    if (!rstN) begin
      shiftReg <= '0;
      inBit    <= 1'b0;
    end else begin
      if (stb.sampleBit) inBit <= serialIn;
      if (stb.loadShift)     shiftReg <= txHead;
      else if (stb.shiftBit) shiftReg <= rxWord;
    end
  end
endmodule

// File: rtl/sfm_ctrl.sv
module sfm_ctrl import sfm_pkg::*; #(
  parameter int W         = 8,
  parameter int DEPTH     = 16,
  parameter int SCK_RATIO = 4,
  parameter int ADDR_W    = 3,
  localparam int CNT_W = $clog2(DEPTH + 1),
  localparam int HALF  = SCK_RATIO / 2,
  localparam int DIV_W = $clog2(HALF + 1),
  localparam int BIT_W = $clog2(W)
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              busReq,
  input  logic              busWe,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic [W-1:0]      busWdata,
  output logic              busAck,
  output logic              busErr,
  output logic [W-1:0]      busRdata,
  input  logic [CNT_W-1:0]  txCount,
  input  logic [CNT_W-1:0]  rxCount,
  input  logic [W-1:0]      rxHead,
  output dpStrobe_t         stb,
  output logic              loopEn,
  output logic              sck,
  output logic              ssN,
  output logic              irq
);
  localparam logic [CNT_W-1:0] FULL_CNT = CNT_W'(DEPTH);
  localparam logic [CNT_W-1:0] HALF_CNT = CNT_W'(DEPTH / 2);

  logic               enable, busy;
  logic [NUM_IRQ-1:0] status, irqEn, evVec, clrVec;
  logic [DIV_W-1:0]   divCnt;
  logic [BIT_W-1:0]   bitCnt;
  logic [W-1:0]       rdMux;
  logic wrTx, rdRx, txFull, rxFull, rxEmpty;
  logic halfDone, lastFall, startNew;

  // bus decode
  assign wrTx    = busReq && busWe && (busAddr == ADDR_W'(ADDR_TX));
  assign rdRx    = busReq && !busWe && (busAddr == ADDR_W'(ADDR_RX));
  assign txFull  = (txCount == FULL_CNT);
  assign rxFull  = (rxCount == FULL_CNT);
  assign rxEmpty = (rxCount == '0);

  // serial sequencing
  assign halfDone = busy && (divCnt == DIV_W'(HALF - 1));
  assign lastFall = halfDone && sck && (bitCnt == BIT_W'(W - 1));
  assign startNew = (!busy || lastFall) && enable && (txCount != '0);

  always_comb begin
    stb           = '0;
    stb.txPush    = wrTx && !txFull;
    stb.rxPop     = rdRx && !rxEmpty;
    stb.loadShift = startNew;
    stb.sampleBit = halfDone && !sck;
    stb.shiftBit  = halfDone && sck && !lastFall;
    stb.rxPush    = lastFall && !rxFull;
  end

  always_comb begin
    evVec              = '0;
    evVec[ST_TXEMPTY]  = startNew && (txCount == CNT_W'(1)) && !stb.txPush;
    evVec[ST_TXHALF]   = startNew && (txCount == HALF_CNT + 1'b1) && !stb.txPush;
    evVec[ST_RXFULL]   = stb.rxPush && (rxCount == FULL_CNT - 1'b1) && !stb.rxPop;
    evVec[ST_OVERRUN]  = lastFall && rxFull;
    evVec[ST_UNDERRUN] = 1'b0;   // master only: never raised
  end

  assign clrVec = (busReq && busWe && busAddr == ADDR_W'(ADDR_STAT))
                  ? busWdata[NUM_IRQ-1:0] : '0;

  always_comb begin
    rdMux = '0;
    case (busAddr)
      ADDR_W'(ADDR_CTRL): rdMux = W'({loopEn, enable});
      ADDR_W'(ADDR_RX):   rdMux = rxEmpty ? '0 : rxHead;
      ADDR_W'(ADDR_STAT): rdMux = W'(status);
      ADDR_W'(ADDR_IEN):  rdMux = W'(irqEn);
      default:            rdMux = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      busAck   <= 1'b0;
      busErr   <= 1'b0;
      busRdata <= '0;
      enable   <= 1'b0;
      loopEn   <= 1'b0;
      irqEn    <= '0;
      status   <= '0;
    end else begin
      busAck   <= busReq;
      busErr   <= (wrTx && txFull) || (rdRx && rxEmpty);
      busRdata <= (busReq && !busWe) ? rdMux : '0;
      if (busReq && busWe && busAddr == ADDR_W'(ADDR_CTRL)) begin
        enable <= busWdata[0];
        loopEn <= busWdata[1];
      end
      if (busReq && busWe && busAddr == ADDR_W'(ADDR_IEN))
        irqEn <= busWdata[NUM_IRQ-1:0];
      status <= (status & ~clrVec) | evVec;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      busy   <= 1'b0;
      sck    <= 1'b0;
      divCnt <= '0;
      bitCnt <= '0;
    end else if (startNew) begin
      busy   <= 1'b1;
      sck    <= 1'b0;
      divCnt <= '0;
      bitCnt <= '0;
    end else if (lastFall) begin
      busy   <= 1'b0;
      sck    <= 1'b0;
      divCnt <= '0;
    end else if (halfDone) begin
      divCnt <= '0;
      sck    <= !sck;
      if (sck) bitCnt <= bitCnt + 1'b1;
    end else if (busy) begin
      divCnt <= divCnt + 1'b1;
    end
  end

  assign ssN = !busy;
  assign irq = |(status & irqEn);
endmodule

// File: rtl/spi_fifo_master.sv
module spi_fifo_master import sfm_pkg::*; #(
  parameter int DATA_W    = 8,
  parameter int DEPTH     = 16,
  parameter int SCK_RATIO = 4,
  parameter int ADDR_W    = 3,
  localparam int CNT_W = $clog2(DEPTH + 1)
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              busReq,
  input  logic              busWe,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic [DATA_W-1:0] busWdata,
  output logic              busAck,
  output logic              busErr,
  output logic [DATA_W-1:0] busRdata,
  output logic              sck,
  output logic              ssN,
  output logic              mosi,
  input  logic              miso,
  output logic              irq
);
  dpStrobe_t         stb;
  logic              loopEn;
  logic [CNT_W-1:0]  txCount, rxCount;
  logic [DATA_W-1:0] rxHead;

  sfm_ctrl #(.W(DATA_W), .DEPTH(DEPTH), .SCK_RATIO(SCK_RATIO), .ADDR_W(ADDR_W)) ctrl_i (
    .clk(clk), .rstN(rstN), .busReq(busReq), .busWe(busWe), .busAddr(busAddr),
    .busWdata(busWdata), .busAck(busAck), .busErr(busErr), .busRdata(busRdata),
    .txCount(txCount), .rxCount(rxCount), .rxHead(rxHead), .stb(stb),
    .loopEn(loopEn), .sck(sck), .ssN(ssN), .irq(irq));

  sfm_datapath #(.W(DATA_W), .DEPTH(DEPTH)) dp_i (
    .clk(clk), .rstN(rstN), .stb(stb), .wrData(busWdata), .misoPin(miso),
    .loopEn(loopEn), .mosi(mosi), .txCount(txCount), .rxCount(rxCount),
    .rxHead(rxHead));
endmodule

// File: rtl/spi_fifo_master_chk.sv
module spi_fifo_master_chk #(
  parameter int DEPTH = 16,
  parameter int CNT_W = 5
) (
  input logic             clk,
  input logic             rstN,
  input logic             busReq,
  input logic             busAck,
  input logic             busErr,
  input logic             sck,
  input logic             ssN,
  input logic             mosi,
  input logic [CNT_W-1:0] txCount,
  input logic [CNT_W-1:0] rxCount
);
  assert_ack_follows_req_R1: assert property (@(posedge clk) disable iff (!rstN)
    busReq |=> busAck);
  assert_tx_bound_R1: assert property (@(posedge clk) disable iff (!rstN)
    txCount <= CNT_W'(DEPTH));
  assert_err_needs_ack_R2: assert property (@(posedge clk) disable iff (!rstN)
    busErr |-> busAck);
  assert_rx_bound_R4: assert property (@(posedge clk) disable iff (!rstN)
    rxCount <= CNT_W'(DEPTH));
  assert_start_needs_data_R7: assert property (@(posedge clk) disable iff (!rstN)
    $fell(ssN) |-> ($past(txCount) != '0));
  assert_sck_idle_R10: assert property (@(posedge clk) disable iff (!rstN)
    ssN |-> !sck);
  assert_mosi_stable_R10: assert property (@(posedge clk) disable iff (!rstN)
    (sck && $past(sck)) |-> $stable(mosi));
endmodule

bind spi_fifo_master spi_fifo_master_chk #(.DEPTH(DEPTH), .CNT_W(CNT_W)) chk_i (
  .clk(clk), .rstN(rstN), .busReq(busReq), .busAck(busAck), .busErr(busErr),
  .sck(sck), .ssN(ssN), .mosi(mosi), .txCount(txCount), .rxCount(rxCount));

// File: tb/spi_fifo_master_tb.sv
module spi_fifo_master_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int RATIO      = 4;
  localparam int DEPTH      = 16;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       busReq = 1'b0, busWe = 1'b0;
  logic [2:0] busAddr = '0;
  logic [7:0] busWdata = '0;
  logic       busAck, busErr, sck, ssN, mosi, miso, irq;
  logic [7:0] busRdata;

  int nChecks = 0, nFail = 0, cyc = 0;

  spi_fifo_master #(.DATA_W(8), .DEPTH(DEPTH), .SCK_RATIO(RATIO), .ADDR_W(3)) dut_i (
    .clk(clk), .rstN(rstN), .busReq(busReq), .busWe(busWe), .busAddr(busAddr),
    .busWdata(busWdata), .busAck(busAck), .busErr(busErr), .busRdata(busRdata),
    .sck(sck), .ssN(ssN), .mosi(mosi), .miso(miso), .irq(irq));

  always #(CLK_PERIOD/2) clk = ~clk;
  always @(negedge clk) cyc++;

  // ---------------- slave model and serial monitor ----------------
  function automatic logic [7:0] slvResp(input int k);
    return 8'(k * 37 + 5);
  endfunction

  logic [7:0] slvShift = '0;
  int         slvBits = 0, slvWordIdx = 0;
  logic [7:0] mosiCap = '0;
  int         mosiBits = 0, capN = 0;
  logic [7:0] capWords [0:1023];
  int         sckRises = 0, ssnRises = 0, badSpacing = 0, lastRise = -1;

  assign miso = slvShift[7];

  always @(negedge ssN) begin
    slvShift = slvResp(slvWordIdx);
    slvBits  = 0;
  end
  always @(posedge ssN) begin
    ssnRises++;
    lastRise = -1;
  end
  always @(negedge sck) if (!ssN) begin
    slvBits++;
    if (slvBits == 8) begin
      slvWordIdx++;
      slvShift = slvResp(slvWordIdx);
      slvBits  = 0;
    end else slvShift = {slvShift[6:0], 1'b0};
  end
  always @(posedge sck) begin
    sckRises++;
    if (lastRise >= 0 && (cyc - lastRise) != RATIO) badSpacing++;
    lastRise = cyc;
    mosiCap = {mosiCap[6:0], mosi};
    mosiBits++;
    if (mosiBits == 8) begin
      capWords[capN] = mosiCap;
      capN++;
      mosiBits = 0;
    end
  end

  // ---------------- helpers ----------------
  task automatic check(input bit ok, input string req, input string what,
                       input int act, input int exp);
    nChecks++;
    if (!ok) begin
      nFail++;
      $display("FAIL %s %s: actual %0d (0x%0h) expected %0d (0x%0h)",
               req, what, act, act, exp, exp);
    end
  endtask

  task automatic busWrite(input logic [2:0] a, input logic [7:0] d, output logic err);
    @(negedge clk);
    busReq = 1'b1; busWe = 1'b1; busAddr = a; busWdata = d;
    @(negedge clk);
    busReq = 1'b0; busWe = 1'b0;
    check(busAck === 1'b1, "R1", "write acknowledge", int'(busAck), 1);
    err = busErr;
  endtask

  task automatic busRead(input logic [2:0] a, output logic [7:0] d, output logic err);
    @(negedge clk);
    busReq = 1'b1; busWe = 1'b0; busAddr = a;
    @(negedge clk);
    busReq = 1'b0;
    check(busAck === 1'b1, "R1", "read acknowledge", int'(busAck), 1);
    d = busRdata; err = busErr;
  endtask

  task automatic waitBurst();
    for (int i = 0; i < 60 && ssN; i++) @(negedge clk);
    for (int i = 0; i < 20000 && !ssN; i++) @(negedge clk);
    repeat (4) @(negedge clk);
  endtask

  function automatic logic [7:0] preWord(input int i);
    return 8'(i * 29 + 3);
  endfunction

  // ---------------- watchdog ----------------
  initial begin
    repeat (150000) @(negedge clk);
    nChecks++; nFail++;
    $display("FAIL watchdog: actual %0d expected %0d cycles", 150000, 0);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFail);
    $finish;
  end

  // ---------------- stimulus ----------------
  initial begin
    logic [7:0] rd;
    logic       er;
    int capBase, slvBase, rBase, ssBase;

    repeat (5) @(negedge clk);
    rstN = 1'b1;
    repeat (2) @(negedge clk);

    // reset state
    check(ssN === 1'b1, "R10", "reset ssN", int'(ssN), 1);
    check(sck === 1'b0, "R10", "reset sck", int'(sck), 0);
    check(irq === 1'b0, "R11", "reset irq", int'(irq), 0);
    busRead(3'd3, rd, er);
    check(rd == 8'h00, "R11", "reset status", rd, 0);
    busRead(3'd0, rd, er);
    check(rd == 8'h00, "R11", "reset control", rd, 0);

    // empty receive read
    busRead(3'd2, rd, er);
    check(er === 1'b1, "R2", "empty rx read error", int'(er), 1);
    check(rd == 8'h00, "R2", "empty rx read data", rd, 0);

    // preload with enable clear
    capBase = capN; slvBase = slvWordIdx; rBase = sckRises; ssBase = ssnRises;
    for (int i = 0; i < DEPTH; i++) begin
      busWrite(3'd1, preWord(i), er);
      check(er === 1'b0, "R1", "preload write no error", int'(er), 0);
    end
    busWrite(3'd1, 8'hAA, er);
    check(er === 1'b1, "R1", "write to full tx error", int'(er), 1);
    repeat (40) @(negedge clk);
    check(ssN === 1'b1, "R8", "idle while disabled", int'(ssN), 1);
    check(capN == capBase, "R8", "no words while disabled", capN, capBase);
    busWrite(3'd0, 8'h01, er);
    waitBurst();
    check(capN - capBase == DEPTH, "R1", "words sent (overflow dropped)", capN - capBase, DEPTH);
    for (int i = 0; i < DEPTH; i++)
      check(capWords[capBase + i] == preWord(i), "R8", "burst word order/MSB-first",
            capWords[capBase + i], preWord(i));
    check(ssnRises - ssBase == 1, "R8", "select rises once per burst", ssnRises - ssBase, 1);
    check(sckRises - rBase == 8 * DEPTH, "R10", "sck rises in burst", sckRises - rBase, 8 * DEPTH);
    check(badSpacing == 0, "R10", "sck period spacing errors", badSpacing, 0);
    busRead(3'd3, rd, er);
    check(rd == 8'h07, "R6", "status after burst (empty, half, rx full)", rd, 8'h07);
    check(rd[2] == 1'b1, "R5", "rx full status bit", int'(rd[2]), 1);
    check(rd[4] == 1'b0, "R6", "underrun never set", int'(rd[4]), 0);

    // overrun: one more word into a full receive queue
    busWrite(3'd1, 8'h5A, er);
    waitBurst();
    busRead(3'd3, rd, er);
    check(rd == 8'h0F, "R4", "overrun status", rd, 8'h0F);
    for (int i = 0; i < DEPTH; i++) begin
      busRead(3'd2, rd, er);
      check(er === 1'b0, "R3", "rx read no error", int'(er), 0);
      check(rd == slvResp(slvBase + i), "R4", "rx order, overrun word dropped",
            rd, slvResp(slvBase + i));
    end
    busRead(3'd2, rd, er);
    check(er === 1'b1, "R3", "read past occupancy error", int'(er), 1);

    // write-1-to-clear
    busWrite(3'd3, 8'h03, er);
    busRead(3'd3, rd, er);
    check(rd == 8'h0C, "R11", "partial clear", rd, 8'h0C);
    busWrite(3'd3, 8'h0C, er);
    busRead(3'd3, rd, er);
    check(rd == 8'h00, "R11", "full clear", rd, 0);

    // enable-first start and interrupt
    busWrite(3'd4, 8'h01, er);
    check(irq === 1'b0, "R11", "irq with no status", int'(irq), 0);
    slvBase = slvWordIdx;
    busWrite(3'd1, 8'h3C, er);
    repeat (2) @(negedge clk);
    check(ssN === 1'b0, "R7", "start right after write", int'(ssN), 0);
    waitBurst();
    check(capWords[capN - 1] == 8'h3C, "R7", "sent word", capWords[capN - 1], 8'h3C);
    check(irq === 1'b1, "R11", "irq on tx empty", int'(irq), 1);
    busWrite(3'd4, 8'h02, er);
    check(irq === 1'b0, "R11", "irq masked", int'(irq), 0);
    busWrite(3'd4, 8'h01, er);
    check(irq === 1'b1, "R11", "irq unmasked", int'(irq), 1);
    busWrite(3'd3, 8'h1F, er);
    check(irq === 1'b0, "R11", "irq after clear", int'(irq), 0);
    busRead(3'd2, rd, er);
    check(rd == slvResp(slvBase), "R3", "single word received", rd, slvResp(slvBase));

    // loopback sweep over all byte values
    busWrite(3'd0, 8'h03, er);
    busRead(3'd0, rd, er);
    check(rd == 8'h03, "R11", "control readback", rd, 8'h03);
    for (int c = 0; c < 16; c++) begin
      for (int i = 0; i < DEPTH; i++) begin
        busWrite(3'd1, 8'(c * 16 + i), er);
        check(er === 1'b0, "R9", "loop write no error", int'(er), 0);
      end
      waitBurst();
      for (int i = 0; i < DEPTH; i++) begin
        busRead(3'd2, rd, er);
        check(rd == 8'(c * 16 + i), "R9", "loopback word", rd, c * 16 + i);
      end
    end

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFail);
    $finish;
  end
endmodule